// File: doc/BRIEF.md
# Eight-Channel Trimmed Dimming PWM Generator

This block drives eight low-frequency dimming PWM lines for lamp inverters. All eight lines share one period and one phase reference. One 8-bit master brightness value sets the common duty cycle. Each channel adds its own small signed trim to that value, so lamps that run brighter or dimmer than their neighbours can be evened out. The sum saturates to the 8-bit range. It is then mapped to a duty level with a fixed floor, so that the lowest code still gives a short pulse and the top code gives a line that stays high.

The period is built from a clock-enable tick. A `STEPS`-step phase counter advances on each tick. A 2-bit mode selects the period source:
- the internal counter alone;
- an external sync input when one is present, with automatic fallback to the internal counter;
- the external sync alone.

A rising sync edge restarts the phase counter. While the block follows the sync and the counter reaches its last step before the next edge, the counter waits there. A sync-present flag reports whether edges have arrived recently.

Outputs are forced low by a global enable (a register bit ANDed with a pin), by a per-channel mask and by a fault-latch input. A new duty value takes effect only at the start of the next period.

Top module: `dimpwm_bank`

## Requirements
- R1: After reset every PWM output is low and `sync_ok` is low.
- R2: In each period, channel n is high for `lvl` steps, where v is the saturated sum of master and trim. If v = 255 then `lvl` = `STEPS` (always high). Otherwise `lvl` = `MIN_STEPS` + floor(v·(`STEPS`−`MIN_STEPS`)/256). With the defaults, v=0 gives 10/256 and v=0x7F gives 132/256.
- R3: Each trim is a 6-bit two's-complement field at bits [6n+5:6n] of `trim_flat`. It is added to the master value, and the sum is clamped to 0..255.
- R4: While `master_en` AND `en_pin` is 0, all outputs are low from the next clock onward.
- R5: Bit n of `ch_mask` equal to 0 holds channel n low.
- R6: While `fault_latched` is 1, all outputs are low from the next clock onward.
- R7: With `sync_mode` = 2'b00 the period is `STEPS` ticks and sync edges have no effect.
- R8: With `sync_mode` = 2'b01, while `sync_ok` is 1 each sync rising edge restarts the period. If the period ends before the next edge, the phase waits at its last step. While `sync_ok` is 0 the internal period is used.
- R9: With `sync_mode` = 2'b10, all outputs are low while `sync_ok` is 0. Otherwise the outputs follow the sync edges as in R8.
- R10: `sync_ok` goes to 1 after a rising edge on `sync_in` (two synchronizer stages). It returns to 0 once 2·`STEPS` ticks pass without an edge.
- R11: A change of master or trim does not alter a period already under way. It takes effect at the next period start.
- R12: `sync_mode` = 2'b11 behaves as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Phase step enable |
| master_lvl | input | 8 | Master brightness code |
| trim_flat | input | NCH*TRIM_W | Packed signed per-channel trims |
| ch_mask | input | NCH | Channel enable mask |
| master_en | input | 1 | Register enable bit |
| en_pin | input | 1 | Enable pin |
| sync_mode | input | 2 | Period source select |
| sync_in | input | 1 | External sync (asynchronous) |
| fault_latched | input | 1 | Forces all outputs low |
| pwm_out | output | NCH | Dimming PWM lines |
| sync_ok | output | 1 | External sync present |

## Verification
The bench builds the block with its defaults: eight channels, 6-bit trims, 256 steps per period and a 10-step floor. It holds `tick_en` high, so one period is 256 clocks and the sync timeout is 512 clocks. This puts many full periods, sync loss and sync recovery within a short run. Sync periods of 150 and 300 clocks test both sides of the nominal period. With a 150-clock sync, a level above 150 saturates at the sync period in follow modes and stays visible in internal mode, so the two modes give different counts.

// File: rtl/dimpwm_pkg.sv
package dimpwm_pkg;

  typedef enum logic [1:0] {
    SM_INTERNAL = 2'b00,
    SM_AUTO     = 2'b01,
    SM_EXTERNAL = 2'b10,
    SM_RESERVED = 2'b11
  } sync_mode_e;

  // Clamp master + signed trim into 0..maxcode
  function automatic int sat_sum(input int master, input int trim, input int maxcode);
    int s;
    s = master + trim;
    if (s < 0) s = 0;
    if (s > maxcode) s = maxcode;
    return s;
  endfunction

  // Map a saturated brightness code to a high-step count per period
  function automatic int duty_level(input int code, input int steps,
                                    input int min_steps, input int maxcode);
    if (code >= maxcode) return steps;
    return min_steps + (code * (steps - min_steps)) / (maxcode + 1);
  endfunction

endpackage

// File: rtl/dimpwm_timebase.sv
module dimpwm_timebase
  import dimpwm_pkg::*;
#(
  parameter int STEPS  = 256,
  parameter int ABSENT = 2 * STEPS,
  localparam int PHASE_W = $clog2(STEPS),
  localparam int GAP_W   = $clog2(ABSENT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               sync_in,
  input  logic [1:0]         sync_mode,
  output logic [PHASE_W-1:0] phase,
  output logic               start_evt,
  output logic               running,
  output logic               sync_ok
);

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(STEPS - 1);

  logic sync_meta, sync_s, sync_d;
  logic sync_edge;
  logic [GAP_W-1:0] gap_cnt;
  logic present_q;
  logic follow, restart, wrap_evt, hold_end;
  sync_mode_e mode;

  assign mode = sync_mode_e'(sync_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_meta <= 1'b0;
      sync_s    <= 1'b0;
      sync_d    <= 1'b0;
    end else begin
      sync_meta <= sync_in;
      sync_s    <= sync_meta;
      sync_d    <= sync_s;
    end
  end

  assign sync_edge = sync_s & ~sync_d;

  // Presence detector: any edge arms, ABSENT ticks of silence disarm
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      present_q <= 1'b0;
    end else if (sync_edge) begin
      gap_cnt   <= '0;
      present_q <= 1'b1;
    end else begin
      if (tick_en && gap_cnt != GAP_W'(ABSENT)) gap_cnt <= gap_cnt + 1'b1;
      if (gap_cnt == GAP_W'(ABSENT)) present_q <= 1'b0;
    end
  end

  always_comb begin
    follow   = (mode == SM_EXTERNAL) || (mode == SM_AUTO && present_q);
    restart  = sync_edge && (mode == SM_EXTERNAL || mode == SM_AUTO);
    hold_end = follow && (phase == LAST);
    wrap_evt = tick_en && (phase == LAST) && !follow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (tick_en && !hold_end) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign start_evt = restart || wrap_evt;
  assign running   = !(mode == SM_EXTERNAL && !present_q);
  assign sync_ok   = present_q;

  assert_present_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(present_q) |-> $past(sync_edge));

  assert_internal_ignores_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SM_INTERNAL && sync_edge && tick_en && phase != LAST) |=> phase != '0);

endmodule

// File: rtl/dimpwm_chan.sv
module dimpwm_chan
  import dimpwm_pkg::*;
#(
  parameter int STEPS     = 256,
  parameter int MIN_STEPS = 10,
  parameter int BRT_W     = 8,
  parameter int TRIM_W    = 6,
  localparam int PHASE_W  = $clog2(STEPS),
  localparam int LVL_W    = PHASE_W + 1,
  localparam int MAXCODE  = (1 << BRT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic [PHASE_W-1:0] phase,
  input  logic [BRT_W-1:0]   master,
  input  logic [TRIM_W-1:0]  trim,
  input  logic               glob_on,
  input  logic               ch_on,
  input  logic               blank,
  output logic               pwm
);

  logic [LVL_W-1:0] level_next, level_q;
  logic             gate_on;
  int               code;

  always_comb begin
    code       = sat_sum(int'(master), int'($signed(trim)), MAXCODE);
    level_next = LVL_W'(duty_level(code, STEPS, MIN_STEPS, MAXCODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         level_q <= '0;
    else if (start_evt) level_q <= level_next;
  end

  assign gate_on = glob_on && ch_on && !blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= gate_on && ({1'b0, phase} < level_q);
  end

  assert_mask_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_on |=> !pwm);

  assert_full_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LVL_W'(STEPS) && gate_on) |=> pwm);

  assert_level_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(level_q));

endmodule

// File: rtl/dimpwm_bank.sv
module dimpwm_bank
  import dimpwm_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int BRT_W     = 8,
  parameter int TRIM_W    = 6,
  parameter int STEPS     = 256,
  parameter int MIN_STEPS = 10,
  localparam int PHASE_W  = $clog2(STEPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic [BRT_W-1:0]      master_lvl,
  input  logic [NCH*TRIM_W-1:0] trim_flat,
  input  logic [NCH-1:0]        ch_mask,
  input  logic                  master_en,
  input  logic                  en_pin,
  input  logic [1:0]            sync_mode,
  input  logic                  sync_in,
  input  logic                  fault_latched,
  output logic [NCH-1:0]        pwm_out,
  output logic                  sync_ok
);

  logic [PHASE_W-1:0] phase;
  logic start_evt, running, glob_on, blank;

  dimpwm_timebase #(.STEPS(STEPS), .ABSENT(2 * STEPS)) tb_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sync_in(sync_in),
    .sync_mode(sync_mode), .phase(phase), .start_evt(start_evt),
    .running(running), .sync_ok(sync_ok)
  );

  assign glob_on = master_en & en_pin;
  assign blank   = fault_latched | ~running;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dimpwm_chan #(
      .STEPS(STEPS), .MIN_STEPS(MIN_STEPS), .BRT_W(BRT_W), .TRIM_W(TRIM_W)
    ) ch_i (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .phase(phase),
      .master(master_lvl), .trim(trim_flat[n*TRIM_W +: TRIM_W]),
      .glob_on(glob_on), .ch_on(ch_mask[n]), .blank(blank), .pwm(pwm_out[n])
    );
  end

  assert_enable_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(master_en && en_pin) |=> pwm_out == '0);

  assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> pwm_out == '0);

  assert_ext_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode == 2'b10 && !sync_ok) |=> pwm_out == '0);

endmodule

// File: tb/dimpwm_bank_tb.sv
module dimpwm_bank_tb_top;

  localparam int NCH = 8;
  localparam int TW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic [7:0] master_lvl = 8'h3F;
  logic [NCH*TW-1:0] trim_flat = '0;
  logic [NCH-1:0] ch_mask = '1;
  logic master_en = 1'b1, en_pin = 1'b1;
  logic [1:0] sync_mode = 2'b00;
  logic sync_in = 1'b0;
  logic fault_latched = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic sync_ok;

  int sync_per = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dimpwm_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .master_lvl(master_lvl),
    .trim_flat(trim_flat), .ch_mask(ch_mask), .master_en(master_en),
    .en_pin(en_pin), .sync_mode(sync_mode), .sync_in(sync_in),
    .fault_latched(fault_latched), .pwm_out(pwm_out), .sync_ok(sync_ok)
  );

  typedef struct {
    int    win;
    int    exp[NCH];
    string tag;
  } item_t;

  item_t sb_q[$];
  event go_ev, done_ev;

  // External sync generator
  initial begin
    forever begin
      if (sync_per == 0) begin
        @(negedge clk);
        sync_in = 1'b0;
      end else begin
        int p;
        p = sync_per;
        @(negedge clk); sync_in = 1'b1;
        repeat (p / 2 - 1) @(negedge clk);
        @(negedge clk); sync_in = 1'b0;
        repeat (p - p / 2 - 1) @(negedge clk);
      end
    end
  end

  function automatic int ref_level(int m, int t);
    int s;
    s = m + t;
    s = (s < 0) ? 0 : ((s > 255) ? 255 : s);
    if (s == 255) return 256;
    return 10 + ((s * 246) >> 8);
  endfunction

  function automatic int trim_of(int n);
    logic signed [TW-1:0] t;
    t = trim_flat[n*TW +: TW];
    return int'(t);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_trim(int n, int v);
    trim_flat[n*TW +: TW] = TW'(v);
  endtask

  // Driver: compute expected per-window high counts, hand to monitor
  task automatic expect_window(int win, bit run, string tag);
    item_t it;
    bit g;
    int l;
    it.win = win;
    it.tag = tag;
    for (int n = 0; n < NCH; n++) begin
      g = master_en && en_pin && !fault_latched && ch_mask[n] && run;
      l = ref_level(int'(master_lvl), trim_of(n));
      it.exp[n] = !g ? 0 : ((l == 256 || l >= win) ? win : l);
    end
    sb_q.push_back(it);
    repeat (600) @(negedge clk);
    -> go_ev;
    @(done_ev);
  endtask

  // Monitor: count high samples over one window and compare
  initial begin
    forever begin
      item_t it;
      int cnt[NCH];
      @(go_ev);
      it = sb_q.pop_front();
      for (int n = 0; n < NCH; n++) cnt[n] = 0;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        for (int n = 0; n < NCH; n++) if (pwm_out[n]) cnt[n]++;
      end
      for (int n = 0; n < NCH; n++) check(cnt[n] == it.exp[n], it.tag, cnt[n], it.exp[n]);
      -> done_ev;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(pwm_out == '0, "R1 pwm", int'(pwm_out), 0);
    check(sync_ok == 1'b0, "R1 sync_ok", int'(sync_ok), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: default master, zero trims
    expect_window(256, 1, "R2 default");
    master_lvl = 8'h7F;
    expect_window(256, 1, "R2 mid");
    master_lvl = 8'hFF;
    expect_window(256, 1, "R2 full");
    master_lvl = 8'h00;
    expect_window(256, 1, "R2 floor");

    // R3: signed trims with saturation on both ends
    master_lvl = 8'h7F;
    set_trim(0, 31); set_trim(1, -32); set_trim(2, 5); set_trim(3, -1);
    set_trim(4, 0);  set_trim(5, 16);  set_trim(6, -17); set_trim(7, 1);
    expect_window(256, 1, "R3 mixed");
    master_lvl = 8'hF0;
    expect_window(256, 1, "R3 sat high");
    master_lvl = 8'h05;
    expect_window(256, 1, "R3 sat low");

    // R5: channel mask
    master_lvl = 8'h90;
    ch_mask = 8'hA5;
    expect_window(256, 1, "R5 mask");
    ch_mask = '1;

    // R4: both enable sources
    master_en = 1'b0;
    expect_window(256, 1, "R4 reg off");
    master_en = 1'b1; en_pin = 1'b0;
    expect_window(256, 1, "R4 pin off");
    en_pin = 1'b1;

    // R6: fault latch
    fault_latched = 1'b1;
    expect_window(256, 1, "R6 fault");
    fault_latched = 1'b0;

    // R11: mid-period change waits for next period
    for (int n = 0; n < NCH; n++) set_trim(n, 0);
    master_lvl = 8'h3F;
    repeat (600) @(negedge clk);
    @(negedge pwm_out[0]);
    @(negedge clk);
    master_lvl = 8'hFF;
    repeat (5) @(negedge clk);
    check(pwm_out[0] == 1'b0, "R11 no early change", int'(pwm_out[0]), 0);
    expect_window(256, 1, "R11 next period");

    // R7: internal mode ignores a fast sync
    master_lvl = 8'hB0;
    sync_per = 150;
    sync_mode = 2'b00;
    expect_window(256, 1, "R7 internal");
    // R12: reserved mode acts as internal
    sync_mode = 2'b11;
    expect_window(256, 1, "R12 reserved");

    // R8: auto mode follows fast and slow sync
    sync_mode = 2'b01;
    expect_window(150, 1, "R8 fast sync");
    check(sync_ok == 1'b1, "R10 present", int'(sync_ok), 1);
    master_lvl = 8'h3F;
    set_trim(2, 31); set_trim(5, -20);
    sync_per = 300;
    expect_window(300, 1, "R8 slow sync");
    master_lvl = 8'hFF;
    expect_window(300, 1, "R8 slow sync full");

    // R10: loss of sync after the timeout window
    master_lvl = 8'h60;
    sync_per = 150;
    repeat (600) @(negedge clk);
    sync_per = 0;
    repeat (300) @(negedge clk);
    check(sync_ok == 1'b1, "R10 still present", int'(sync_ok), 1);
    repeat (300) @(negedge clk);
    check(sync_ok == 1'b0, "R10 timed out", int'(sync_ok), 0);
    // R8: fallback to internal period
    expect_window(256, 1, "R8 fallback");

    // R9: external-only mode
    sync_mode = 2'b10;
    expect_window(256, 0, "R9 no sync");
    sync_per = 150;
    master_lvl = 8'hB0;
    expect_window(150, 1, "R9 with sync");

    finish_run();
  end

endmodule